// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the integer execute stage of a small load/store RISC core. Each cycle it receives two 32-bit register operands, a 5-bit shift count, a 16-bit immediate and an operation code. It returns a 32-bit result together with a zero flag and a signed-overflow flag. The operations are addition and subtraction in signed and unsigned flavours, bitwise AND and OR, logical shifts by a constant count, signed and unsigned set-less-than, and placement of an immediate into the upper half-word. An immediate-select input replaces the second operand with the extended immediate. This covers the register-immediate forms and the base-plus-offset address computation for loads and stores.

The result and flags are captured in an output register, so they appear one clock after the inputs. The branch logic of the core reads the zero flag after a subtract to decide equal or not-equal branches. A full 32-bit constant is built from an upper-immediate placement followed by an OR with the low half-word.

Top module: `risc_exec_alu`

## Requirements
- R1: `op_i` encodings are 0 add, 1 add-unsigned, 2 subtract, 3 subtract-unsigned, 4 AND, 5 OR, 6 shift-left, 7 shift-right, 8 signed less-than, 9 unsigned less-than, 10 upper-immediate. Add and subtract results wrap modulo 2^32.
- R2: AND and OR give the bitwise combination of `src_a_i` and the second operand.
- R3: `ovf_o` is 1 for signed add (code 0) or signed subtract (code 2) when the true signed result does not fit in 32 bits. It is 0 for every other code, including the unsigned add and subtract and both less-than compares.
- R4: When `use_imm_i` is 1, the second operand is `imm_i`: zero-extended for AND and OR, and sign-extended for add, subtract and the compares. When `use_imm_i` is 0, `imm_i` has no effect on those codes. OR with an immediate leaves result bits 31:16 equal to `src_a_i[31:16]`.
- R5: Code 10 returns `imm_i` in bits 31:16 and zeros in bits 15:0, whatever the operands and `use_imm_i` are.
- R6: Codes 6 and 7 shift `src_a_i` left or right by `shamt_i` places and fill with zeros. A count of 0 returns `src_a_i` unchanged.
- R7: Codes 8 and 9 return 1 when `src_a_i` is less than the second operand, taken as two's-complement and as unsigned respectively, and 0 otherwise.
- R8: `zero_o` is 1 exactly when the registered result is all zeros.
- R9: Results and flags appear on the outputs one clock edge after the inputs are presented. A synchronous active-high reset drives result 0, `zero_o` 1 and `ovf_o` 0.
- R10: Codes 11 to 15 return result 0 with `ovf_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Select extended immediate as second operand |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second register operand |
| shamt_i | input | 5 | Shift count |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered result-is-zero flag |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
Every result and both flags are due exactly one rising edge after the operation is applied, because a single output register sits behind the combinational datapath. The bench changes the inputs on a falling edge. It then compares all three outputs on the next falling edge, so exactly one capture edge lies between stimulus and check. The reset values are checked the same way, one edge after reset is raised. The properties in the checker use the same one-edge relation between an operation and its registered result.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    localparam int XLEN  = 32;
    localparam int IMMW  = 16;
    localparam int SHW   = $clog2(XLEN);
    localparam int OPW   = 4;
    localparam int MSB   = XLEN - 1;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_LUI  = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic            sub;
    } addsub_req_t;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic            ovf;
        logic            lt_s;
        logic            lt_u;
    } addsub_rsp_t;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            zero;
        logic            ovf;
    } exec_out_t;

    // Operations that run the adder in subtract mode.
    function automatic logic op_uses_sub(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBU) ||
               (op == OP_SLT) || (op == OP_SLTU);
    endfunction

    // Bitwise immediates are zero-extended; everything else sign-extends.
    function automatic logic op_zero_ext(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR);
    endfunction

    // Only the signed add and subtract report overflow.
    function automatic logic op_flags_ovf(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/rxa_operand_sel.sv
module rxa_operand_sel
    import rxa_pkg::*;
(
    input  alu_op_e         op,
    input  logic            use_imm,
    input  logic [XLEN-1:0] reg_b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] opnd_b
);
    localparam int EXTW = XLEN - IMMW;

    logic [XLEN-1:0] imm_ext;

    always_comb begin
        if (op_zero_ext(op)) begin
            imm_ext = {{EXTW{1'b0}}, imm};
        end else begin
            imm_ext = {{EXTW{imm[IMMW-1]}}, imm};
        end
        opnd_b = use_imm ? imm_ext : reg_b;
    end

endmodule

// File: rtl/rxa_addsub.sv
module rxa_addsub
    import rxa_pkg::*;
(
    input  addsub_req_t req,
    output addsub_rsp_t rsp
);
    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   wide;

    always_comb begin
        b_eff    = req.b ^ {XLEN{req.sub}};
        wide     = {1'b0, req.a} + {1'b0, b_eff} + {{XLEN{1'b0}}, req.sub};
        rsp.sum  = wide[XLEN-1:0];
        // Same effective sign in, different sign out.
        rsp.ovf  = (req.a[MSB] == b_eff[MSB]) && (rsp.sum[MSB] != req.a[MSB]);
        // Valid in subtract mode only.
        rsp.lt_s = rsp.sum[MSB] ^ rsp.ovf;
        rsp.lt_u = ~wide[XLEN];
    end

endmodule

// File: rtl/rxa_shifter.sv
module rxa_shifter
    import rxa_pkg::*;
(
    input  logic [XLEN-1:0] din,
    input  logic [SHW-1:0]  amt,
    output logic [XLEN-1:0] shl,
    output logic [XLEN-1:0] shr
);
    logic [XLEN-1:0] lstg [SHW+1];
    logic [XLEN-1:0] rstg [SHW+1];

    assign lstg[0] = din;
    assign rstg[0] = din;

    genvar s;
    generate
        for (s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            assign lstg[s+1] = amt[s] ? {lstg[s][XLEN-1-DIST:0], {DIST{1'b0}}} : lstg[s];
            assign rstg[s+1] = amt[s] ? {{DIST{1'b0}}, rstg[s][XLEN-1:DIST]} : rstg[s];
        end
    endgenerate

    assign shl = lstg[SHW];
    assign shr = rstg[SHW];

endmodule

// File: rtl/risc_exec_alu.sv
module risc_exec_alu
    import rxa_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      op_i,
    input  logic            use_imm_i,
    input  logic [31:0]     src_a_i,
    input  logic [31:0]     src_b_i,
    input  logic [4:0]      shamt_i,
    input  logic [15:0]     imm_i,
    output logic [31:0]     result_o,
    output logic            zero_o,
    output logic            ovf_o
);
    localparam int LOW = XLEN - IMMW;

    alu_op_e         op;
    logic [XLEN-1:0] opnd_b;
    addsub_req_t     as_req;
    addsub_rsp_t     as_rsp;
    logic [XLEN-1:0] sh_left;
    logic [XLEN-1:0] sh_right;
    exec_out_t       nxt;
    exec_out_t       q;

    assign op = alu_op_e'(op_i);

    rxa_operand_sel u_opsel (
        .op      (op),
        .use_imm (use_imm_i),
        .reg_b   (src_b_i),
        .imm     (imm_i),
        .opnd_b  (opnd_b)
    );

    always_comb begin
        as_req.a   = src_a_i;
        as_req.b   = opnd_b;
        as_req.sub = op_uses_sub(op);
    end

    rxa_addsub u_addsub (
        .req (as_req),
        .rsp (as_rsp)
    );

    rxa_shifter u_shift (
        .din (src_a_i),
        .amt (shamt_i),
        .shl (sh_left),
        .shr (sh_right)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU: nxt.result = as_rsp.sum;
            OP_AND:          nxt.result = src_a_i & opnd_b;
            OP_OR:           nxt.result = src_a_i | opnd_b;
            OP_SLL:          nxt.result = sh_left;
            OP_SRL:          nxt.result = sh_right;
            OP_SLT:          nxt.result = {{(XLEN-1){1'b0}}, as_rsp.lt_s};
            OP_SLTU:         nxt.result = {{(XLEN-1){1'b0}}, as_rsp.lt_u};
            OP_LUI:          nxt.result = {imm_i, {LOW{1'b0}}};
            default:         nxt.result = '0;
        endcase
        nxt.ovf  = op_flags_ovf(op) & as_rsp.ovf;
        nxt.zero = (nxt.result == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.result <= '0;
            q.zero   <= 1'b1;
            q.ovf    <= 1'b0;
        end else begin
            q <= nxt;
        end
    end

    assign result_o = q.result;
    assign zero_o   = q.zero;
    assign ovf_o    = q.ovf;

endmodule

// File: rtl/risc_exec_alu_chk.sv
module risc_exec_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic        use_imm_i,
    input logic [31:0] src_a_i,
    input logic [31:0] src_b_i,
    input logic [4:0]  shamt_i,
    input logic [15:0] imm_i,
    input logic [31:0] result_o,
    input logic        zero_o,
    input logic        ovf_o
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd1 || op_i == 4'd3 || op_i == 4'd8 || op_i == 4'd9) |=> !ovf_o);

    // R4
    ori_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd5 && use_imm_i) |=> result_o[31:16] == $past(src_a_i[31:16]));

    // R5
    lui_place_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd10) |=> (result_o[15:0] == 16'h0 && result_o[31:16] == $past(imm_i)));

    // R6
    srl_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7 && shamt_i != 5'd0) |=> !result_o[31]);

    // R7
    slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 || op_i == 4'd9) |=> result_o[31:1] == 31'h0);

    // R8
    zero_and_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd4 && !use_imm_i && src_b_i == 32'h0) |=> (zero_o && result_o == 32'h0));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (result_o == 32'h0 && zero_o && !ovf_o));

    // R10
    bad_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 4'd11) |=> (result_o == 32'h0 && !ovf_o));

endmodule

bind risc_exec_alu risc_exec_alu_chk u_chk (.*);

// File: tb/risc_exec_alu_tb.sv
module risc_exec_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic        use_imm_i = 1'b0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] result_o;
    logic        zero_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    risc_exec_alu dut_i (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic        im;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [15:0] iv;
        logic [31:0] res;
        logic        z;
        logic        v;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 32'h2,        32'h3,        5'd0,  16'h0,    32'h5,        1'b0, 1'b0, 8'd1},  // R1
        '{4'd0, 1'b0, 32'h7FFFFFFF, 32'h1,        5'd0,  16'h0,    32'h80000000, 1'b0, 1'b1, 8'd3},  // R3
        '{4'd1, 1'b0, 32'h7FFFFFFF, 32'h1,        5'd0,  16'h0,    32'h80000000, 1'b0, 1'b0, 8'd3},  // R3
        '{4'd2, 1'b0, 32'h5,        32'h5,        5'd0,  16'h0,    32'h0,        1'b1, 1'b0, 8'd8},  // R8
        '{4'd2, 1'b0, 32'h80000000, 32'h1,        5'd0,  16'h0,    32'h7FFFFFFF, 1'b0, 1'b1, 8'd3},  // R3
        '{4'd3, 1'b0, 32'h0,        32'h1,        5'd0,  16'h0,    32'hFFFFFFFF, 1'b0, 1'b0, 8'd1},  // R1
        '{4'd4, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 5'd0,  16'h0,    32'hF000F000, 1'b0, 1'b0, 8'd2},  // R2
        '{4'd5, 1'b0, 32'hF0F0F0F0, 32'h0F0F0000, 5'd0,  16'h0,    32'hFFFFF0F0, 1'b0, 1'b0, 8'd2},  // R2
        '{4'd4, 1'b1, 32'hFFFFFFFF, 32'h0,        5'd0,  16'h8001, 32'h00008001, 1'b0, 1'b0, 8'd4},  // R4
        '{4'd5, 1'b1, 32'hAAAA0000, 32'h0,        5'd0,  16'hAAAA, 32'hAAAAAAAA, 1'b0, 1'b0, 8'd4},  // R4
        '{4'd10,1'b0, 32'h12345678, 32'h9,        5'd3,  16'h00FF, 32'h00FF0000, 1'b0, 1'b0, 8'd5},  // R5
        '{4'd0, 1'b1, 32'h14,       32'h0,        5'd0,  16'hFFFC, 32'h10,       1'b0, 1'b0, 8'd4},  // R4
        '{4'd0, 1'b1, 32'h7FFFFFFF, 32'h0,        5'd0,  16'h0001, 32'h80000000, 1'b0, 1'b1, 8'd3},  // R3
        '{4'd6, 1'b0, 32'h1,        32'h0,        5'd31, 16'h0,    32'h80000000, 1'b0, 1'b0, 8'd6},  // R6
        '{4'd6, 1'b0, 32'h12345678, 32'h0,        5'd4,  16'h0,    32'h23456780, 1'b0, 1'b0, 8'd6},  // R6
        '{4'd7, 1'b0, 32'h80000000, 32'h0,        5'd31, 16'h0,    32'h1,        1'b0, 1'b0, 8'd6},  // R6
        '{4'd7, 1'b0, 32'hF0000000, 32'h0,        5'd4,  16'h0,    32'h0F000000, 1'b0, 1'b0, 8'd6},  // R6
        '{4'd8, 1'b0, 32'hFFFFFFFF, 32'h1,        5'd0,  16'h0,    32'h1,        1'b0, 1'b0, 8'd7},  // R7
        '{4'd9, 1'b0, 32'hFFFFFFFF, 32'h1,        5'd0,  16'h0,    32'h0,        1'b1, 1'b0, 8'd7},  // R7
        '{4'd8, 1'b0, 32'h7FFFFFFF, 32'h80000000, 5'd0,  16'h0,    32'h0,        1'b1, 1'b0, 8'd7},  // R7
        '{4'd9, 1'b0, 32'h7FFFFFFF, 32'h80000000, 5'd0,  16'h0,    32'h1,        1'b0, 1'b0, 8'd7},  // R7
        '{4'd8, 1'b0, 32'h80000000, 32'h1,        5'd0,  16'h0,    32'h1,        1'b0, 1'b0, 8'd3},  // R3 R7
        '{4'd8, 1'b1, 32'hFFFFFFFE, 32'h0,        5'd0,  16'hFFFF, 32'h1,        1'b0, 1'b0, 8'd4},  // R4
        '{4'd9, 1'b1, 32'h5,        32'h0,        5'd0,  16'hFFFF, 32'h1,        1'b0, 1'b0, 8'd4},  // R4
        '{4'd8, 1'b0, 32'h3,        32'h3,        5'd0,  16'h0,    32'h0,        1'b1, 1'b0, 8'd7},  // R7
        '{4'd15,1'b0, 32'h1,        32'h1,        5'd0,  16'h0,    32'h0,        1'b1, 1'b0, 8'd10}, // R10
        '{4'd6, 1'b0, 32'hABCD1234, 32'h0,        5'd0,  16'h0,    32'hABCD1234, 1'b0, 1'b0, 8'd6},  // R6
        '{4'd5, 1'b0, 32'h1,        32'h2,        5'd0,  16'hFFFF, 32'h3,        1'b0, 1'b0, 8'd4},  // R4
        '{4'd2, 1'b1, 32'h0,        32'h0,        5'd0,  16'h0001, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd4}   // R4
    };

    task automatic check_out(input int rq, input logic [31:0] er, input logic ez, input logic ev);
        checks++;
        if (result_o !== er || zero_o !== ez || ovf_o !== ev) begin
            errors++;
            $display("FAIL R%0d: got result=%h zero=%b ovf=%b, expected result=%h zero=%b ovf=%b",
                     rq, result_o, zero_o, ovf_o, er, ez, ev);
        end
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state, one edge after reset is held
        @(negedge clk);
        @(negedge clk);
        check_out(9, 32'h0, 1'b1, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_i      = VECS[i].op;
            use_imm_i = VECS[i].im;
            src_a_i   = VECS[i].a;
            src_b_i   = VECS[i].b;
            shamt_i   = VECS[i].sh;
            imm_i     = VECS[i].iv;
            @(negedge clk);
            check_out(int'(VECS[i].rq), VECS[i].res, VECS[i].z, VECS[i].v);
        end

        // R9: one-cycle latency, output still holds previous op before the edge
        @(negedge clk);
        op_i = 4'd0; use_imm_i = 1'b0; src_a_i = 32'h10; src_b_i = 32'h20;
        #1 check_out(9, 32'hFFFFFFFF, 1'b0, 1'b0);
        @(negedge clk);
        check_out(9, 32'h30, 1'b0, 1'b0);

        // R9: synchronous reset clears an overflowing result
        op_i = 4'd0; src_a_i = 32'h7FFFFFFF; src_b_i = 32'h7FFFFFFF;
        @(negedge clk);
        check_out(3, 32'hFFFFFFFE, 1'b0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check_out(9, 32'h0, 1'b1, 1'b0);
        rst = 1'b0;

        // R5 with immediate select low and R4 constant build: upper then OR low
        op_i = 4'd10; use_imm_i = 1'b1; imm_i = 16'hDEAD; src_a_i = 32'hFFFFFFFF;
        @(negedge clk);
        check_out(5, 32'hDEAD0000, 1'b0, 1'b0);
        op_i = 4'd5; use_imm_i = 1'b1; src_a_i = 32'hDEAD0000; imm_i = 16'hBEEF;
        @(negedge clk);
        check_out(4, 32'hDEADBEEF, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule